// File: doc/BRIEF.md
# I2C Bus Monitor

This block listens to the two wires of an I2C bus without ever driving them. Both lines are resynchronised to the system clock. The block then recognises bus conditions, collects address and data bytes, samples each acknowledge bit and gives every byte a class. It is meant to sit beside a bus as a protocol probe, with its event stream feeding a trace buffer or a debug counter.

Each recognised event appears as a one-cycle `event_valid` pulse that carries a four-bit code and a byte. When a frame closes with STOP, the block also reports two figures in the same cycle: how many times the line pair changed, and how many clock cycles the frame lasted since its opening START.

Top module: `i2c_bus_monitor`

## Requirements
- R1: While reset is held and right after it, `event_valid`, `frame_done`, `trans_count` and `cycle_count` are zero, and both line levels are taken as high (idle bus).
- R2: From idle, a falling SDA while SCL is high gives event code 0 (start) with byte 0 and opens a frame.
- R3: Bits are taken on rising SCL, most significant first. After the eighth bit of the first byte of a frame, the block emits code 5 when bit 0 is 1 (read) and code 6 when it is 0 (write). The reported byte is the received byte shifted right by one when `addr_raw` is 0, and the whole received byte when `addr_raw` is 1.
- R4: The rising SCL after each eighth bit is the acknowledge. SDA low there gives code 3, and SDA high gives code 4, both with byte 0.
- R5: Every further byte in the frame gives code 7 if the address marked a read and code 8 if it marked a write. The byte is reported as received.
- R6: A START seen after an acknowledge, with no STOP since the last START, gives code 1. It restarts address collection, and the new address sets the direction again.
- R7: A rising SDA while SCL is high, seen after an acknowledge (including part-way through a later byte), gives code 2 and ends the frame. The next START is then reported with code 0.
- R8: START and STOP patterns are ignored while an address byte or an acknowledge is awaited. In idle, STOP patterns and SCL pulses produce no event.
- R9: `frame_done` pulses in the same cycle as the code-2 event. `trans_count` is the number of changes of the synchronised SCL/SDA pair after the opening (or latest repeated) START, up to and including the STOP. `cycle_count` is the number of clock cycles from the START detection to the STOP detection, both included.
- R10: Both frame counters stop at their all-ones value instead of wrapping.
- R11: `event_valid` lasts one cycle per event, and codes 0 to 4 carry byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_raw | input | 1 | 1: report the full address byte; 0: report it shifted right by one |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| event_valid | output | 1 | One-cycle event strobe |
| event_code | output | 4 | Event class, 0 to 8 |
| event_byte | output | BYTE_W | Address or data byte, 0 for condition events |
| frame_done | output | 1 | Pulse when a frame closes with STOP |
| trans_count | output | TRANS_W | Line-pair changes in the closed frame |
| cycle_count | output | CYC_W | Clock cycles from START to STOP, inclusive |

## Verification
Whole frames are run from a table of address bytes, data bytes, acknowledge values and address-format settings. The table spans read and write, ACK and NACK, both address formats and all-zero and all-one patterns, so a wrong shift direction, bit order or direction inheritance shows up as a wrong code or byte. Directed frames add START and STOP glitches inside an address byte and inside an acknowledge slot. They also cover a repeated START that flips direction, a STOP part-way through a data byte followed by a fresh START, and bus activity with no frame open. These cases separate the phases in which conditions are honoured from those in which they are not. A second instance with a narrow transition counter shows the counter stopping at its limit rather than wrapping.

// File: rtl/mon_pkg.sv
package mon_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_ACK  = 2'd2,
    PH_DATA = 2'd3
  } phase_t;

  typedef enum logic [3:0] {
    EV_START   = 4'd0,
    EV_RSTART  = 4'd1,
    EV_STOP    = 4'd2,
    EV_ACK     = 4'd3,
    EV_NACK    = 4'd4,
    EV_ADDR_RD = 4'd5,
    EV_ADDR_WR = 4'd6,
    EV_DATA_RD = 4'd7,
    EV_DATA_WR = 4'd8
  } ev_code_t;
endpackage

// File: rtl/mon_line_sync.sv
module mon_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] line_in,
  output logic [LINES-1:0] level,
  output logic [LINES-1:0] level_q
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], line_in[g]};
    end
    assign level[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) level_q <= '1;
    else     level_q <= level;
  end

  // R1: idle bus seen as high for the first cycle after reset
  assert_idle_after_reset_R1: assert property (@(posedge clk)
    $fell(rst) |-> (level_q == '1));
endmodule

// File: rtl/mon_frame_meter.sv
module mon_frame_meter #(
  parameter int TRANS_W = 16,
  parameter int CYC_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pair_chg,
  input  logic               open,
  input  logic               close,
  output logic               frame_done,
  output logic [TRANS_W-1:0] trans_count,
  output logic [CYC_W-1:0]   cycle_count
);
  localparam logic [TRANS_W-1:0] T_MAX = '1;
  localparam logic [CYC_W-1:0]   C_MAX = '1;

  logic               active;
  logic [TRANS_W-1:0] tr, tr_nx;
  logic [CYC_W-1:0]   cyc, cyc_nx;

  always_comb begin
    tr_nx  = (pair_chg && tr != T_MAX) ? tr + 1'b1 : tr;
    cyc_nx = (cyc != C_MAX) ? cyc + 1'b1 : cyc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active      <= 1'b0;
      tr          <= '0;
      cyc         <= '0;
      frame_done  <= 1'b0;
      trans_count <= '0;
      cycle_count <= '0;
    end else begin
      frame_done <= 1'b0;
      if (open) begin
        active <= 1'b1;
        tr     <= '0;
        cyc    <= CYC_W'(1);
      end else if (active) begin
        tr  <= tr_nx;
        cyc <= cyc_nx;
        if (close) begin
          active      <= 1'b0;
          frame_done  <= 1'b1;
          trans_count <= tr_nx;
          cycle_count <= cyc_nx;
        end
      end
    end
  end

  // R10: the running counters never fall back while a frame stays open
  assert_trans_no_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    (active && !open && !close) |=> (tr >= $past(tr)));
  assert_cycles_no_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    (active && !open) |=> (cyc != '0));
  // R9: a closed frame always spans at least the START and STOP cycles
  assert_min_span_R9: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (cycle_count >= CYC_W'(2)));
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import mon_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int TRANS_W     = 16,
  parameter int CYC_W       = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               addr_raw,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               event_valid,
  output logic [3:0]         event_code,
  output logic [BYTE_W-1:0]  event_byte,
  output logic               frame_done,
  output logic [TRANS_W-1:0] trans_count,
  output logic [CYC_W-1:0]   cycle_count
);
  localparam int NB_W = $clog2(BYTE_W);
  localparam logic [NB_W-1:0] LAST_BIT = NB_W'(BYTE_W - 1);

  logic [1:0] lvl, lvl_q;
  logic       scl, sda, scl_q, sda_q;
  logic       scl_rise, start_pat, stop_pat, pair_chg;
  logic       take_start, take_stop;

  mon_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .line_in ({scl_in, sda_in}),
    .level   (lvl),
    .level_q (lvl_q)
  );

  assign scl   = lvl[1];
  assign sda   = lvl[0];
  assign scl_q = lvl_q[1];
  assign sda_q = lvl_q[0];

  assign scl_rise  = scl & ~scl_q;
  assign start_pat = scl & sda_q & ~sda;
  assign stop_pat  = scl & ~sda_q & sda;
  assign pair_chg  = (lvl != lvl_q);

  phase_t            ph;
  logic [BYTE_W-1:0] shreg, byte_nx, addr_rep;
  logic [NB_W-1:0]   nbits;
  logic              dir_rd, rep;
  logic              ev_v;
  ev_code_t          ev_c;
  logic [BYTE_W-1:0] ev_b;

  always_comb begin
    byte_nx    = {shreg[BYTE_W-2:0], sda};
    addr_rep   = addr_raw ? byte_nx : (byte_nx >> 1);
    take_start = start_pat && (ph == PH_IDLE || (ph == PH_DATA && !scl_rise));
    take_stop  = stop_pat && ph == PH_DATA && !scl_rise;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      shreg  <= '0;
      nbits  <= '0;
      dir_rd <= 1'b0;
      rep    <= 1'b0;
      ev_v   <= 1'b0;
      ev_c   <= EV_START;
      ev_b   <= '0;
    end else begin
      ev_v <= 1'b0;
      if (take_start) begin
        ev_v   <= 1'b1;
        ev_c   <= rep ? EV_RSTART : EV_START;
        ev_b   <= '0;
        rep    <= 1'b1;
        dir_rd <= 1'b0;
        nbits  <= '0;
        ph     <= PH_ADDR;
      end else if (take_stop) begin
        ev_v   <= 1'b1;
        ev_c   <= EV_STOP;
        ev_b   <= '0;
        rep    <= 1'b0;
        dir_rd <= 1'b0;
        nbits  <= '0;
        ph     <= PH_IDLE;
      end else if (scl_rise) begin
        unique case (ph)
          PH_ADDR, PH_DATA: begin
            shreg <= byte_nx;
            nbits <= nbits + 1'b1;
            if (nbits == LAST_BIT) begin
              nbits <= '0;
              ev_v  <= 1'b1;
              ph    <= PH_ACK;
              if (ph == PH_ADDR) begin
                dir_rd <= byte_nx[0];
                ev_c   <= byte_nx[0] ? EV_ADDR_RD : EV_ADDR_WR;
                ev_b   <= addr_rep;
              end else begin
                ev_c <= dir_rd ? EV_DATA_RD : EV_DATA_WR;
                ev_b <= byte_nx;
              end
            end
          end
          PH_ACK: begin
            ev_v  <= 1'b1;
            ev_c  <= sda ? EV_NACK : EV_ACK;
            ev_b  <= '0;
            nbits <= '0;
            ph    <= PH_DATA;
          end
          default: ;
        endcase
      end
    end
  end

  assign event_valid = ev_v;
  assign event_code  = ev_c;
  assign event_byte  = ev_b;

  mon_frame_meter #(.TRANS_W(TRANS_W), .CYC_W(CYC_W)) u_meter (
    .clk         (clk),
    .rst         (rst),
    .pair_chg    (pair_chg),
    .open        (take_start),
    .close       (take_stop),
    .frame_done  (frame_done),
    .trans_count (trans_count),
    .cycle_count (cycle_count)
  );

  // R2: a plain start is only reported out of the idle phase
  assert_start_from_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (ev_v && ev_c == EV_START) |-> ($past(ph) == PH_IDLE));
  // R6: a repeated start needs an unclosed frame
  assert_rstart_needs_frame_R6: assert property (@(posedge clk) disable iff (rst)
    (ev_v && ev_c == EV_RSTART) |-> $past(rep));
  // R8: the address phase is entered only through an honoured start
  assert_addr_entry_R8: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_ADDR && $past(ph) != PH_ADDR) |-> $past(take_start));
  // R3: the acknowledge slot always begins a fresh bit count
  assert_ack_bitcount_R3: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_ACK) |-> (nbits == '0));
  // R9: frame figures come out together with the stop event
  assert_done_with_stop_R9: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (ev_v && ev_c == EV_STOP));
  // R11: condition and acknowledge events carry no byte
  assert_cond_byte_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (ev_v && ev_c <= EV_NACK) |-> (ev_b == '0));
endmodule

// File: tb/i2c_bus_monitor_tb.sv
module i2c_bus_monitor_tb;
  localparam int EV_START = 0, EV_RSTART = 1, EV_STOP = 2, EV_ACK = 3, EV_NACK = 4;
  localparam int EV_ARD = 5, EV_AWR = 6, EV_DRD = 7, EV_DWR = 8;
  localparam int HOLD = 4;

  // {addr_raw, address byte, address ack, data byte, data ack}
  localparam logic [18:0] VEC [6] = '{
    {1'b0, 8'hA2, 1'b0, 8'h3C, 1'b0},
    {1'b0, 8'hA3, 1'b1, 8'h81, 1'b1},
    {1'b1, 8'h7F, 1'b0, 8'h00, 1'b1},
    {1'b1, 8'h40, 1'b1, 8'hFF, 1'b0},
    {1'b0, 8'h01, 1'b0, 8'h55, 1'b0},
    {1'b0, 8'hFE, 1'b1, 8'hAA, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic addr_raw = 1'b0;
  logic scl_d = 1'b1, sda_d = 1'b1;

  logic        ev_valid, done, sat_done, sat_ev_valid;
  logic [3:0]  ev_code, sat_code;
  logic [7:0]  ev_byte, sat_byte;
  logic [15:0] tr_cnt;
  logic [31:0] cy_cnt, sat_cy;
  logic [3:0]  sat_tr;

  always #2.5 clk = ~clk;

  i2c_bus_monitor u_dut (
    .clk(clk), .rst(rst), .addr_raw(addr_raw), .scl_in(scl_d), .sda_in(sda_d),
    .event_valid(ev_valid), .event_code(ev_code), .event_byte(ev_byte),
    .frame_done(done), .trans_count(tr_cnt), .cycle_count(cy_cnt)
  );

  i2c_bus_monitor #(.TRANS_W(4)) u_sat (
    .clk(clk), .rst(rst), .addr_raw(addr_raw), .scl_in(scl_d), .sda_in(sda_d),
    .event_valid(sat_ev_valid), .event_code(sat_code), .event_byte(sat_byte),
    .frame_done(sat_done), .trans_count(sat_tr), .cycle_count(sat_cy)
  );

  int n_chk = 0, n_fail = 0;
  int ev_n = 0, done_n = 0, pulse_err = 0;
  int log_code [0:127];
  int log_byte [0:127];
  int last_tr = 0, last_cy = 0, last_sat = 0;
  logic prev_v = 1'b0;
  int bt = 0, steps = 0, step_start = 0, step_stop = 0;
  bit finished = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (ev_valid) begin
        if (prev_v) pulse_err++;
        if (ev_n < 128) begin
          log_code[ev_n] = int'(ev_code);
          log_byte[ev_n] = int'(ev_byte);
        end
        ev_n++;
      end
      prev_v = ev_valid;
      if (done) begin
        done_n++;
        last_tr = int'(tr_cnt);
        last_cy = int'(cy_cnt);
      end
      if (sat_done) last_sat = int'(sat_tr);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input logic c, input logic d);
    @(negedge clk);
    if ({c, d} != {scl_d, sda_d}) bt++;
    scl_d = c;
    sda_d = d;
    steps++;
    repeat (HOLD - 1) @(negedge clk);
  endtask

  task automatic bus_start();
    put(1'b0, sda_d);
    put(1'b0, 1'b1);
    put(1'b1, 1'b1);
    put(1'b1, 1'b0);
    bt = 0;
    step_start = steps;
  endtask

  task automatic bus_stop();
    put(1'b0, sda_d);
    put(1'b0, 1'b0);
    put(1'b1, 1'b0);
    put(1'b1, 1'b1);
    step_stop = steps;
  endtask

  task automatic send_bit(input logic b);
    put(1'b0, sda_d);
    put(1'b0, b);
    put(1'b1, b);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  task automatic expect_ev(input string req, input int idx, input int code, input int byt);
    chk({req, " code"}, (idx < ev_n) ? log_code[idx] : -1, code);
    chk({req, " byte"}, (idx < ev_n) ? log_byte[idx] : -1, byt);
  endtask

  task automatic expect_counts(input string req, input int done_before);
    chk({req, " frame_done pulses"}, done_n - done_before, 1);
    chk({req, " trans_count"}, last_tr, bt);
    chk({req, " cycle_count"}, last_cy, (step_stop - step_start) * HOLD + 1);
    chk("R10 saturated trans_count", last_sat, (bt > 15) ? 15 : bt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int mark, dmark;
    logic [7:0] a, d;
    logic aa, da, rw;
    repeat (5) @(negedge clk);
    chk("R1 event_valid in reset", int'(ev_valid), 0);
    chk("R1 frame_done in reset", int'(done), 0);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    chk("R1 events after reset", ev_n, 0);
    chk("R1 trans_count after reset", int'(tr_cnt), 0);
    chk("R1 cycle_count after reset", int'(cy_cnt), 0);

    // table of complete frames
    foreach (VEC[k]) begin
      addr_raw = VEC[k][18];
      a  = VEC[k][17:10];
      aa = VEC[k][9];
      d  = VEC[k][8:1];
      da = VEC[k][0];
      rw = a[0];
      mark = ev_n;
      dmark = done_n;
      bus_start();
      send_byte(a);
      send_bit(aa);
      send_byte(d);
      send_bit(da);
      bus_stop();
      settle();
      chk("R11 event count per frame", ev_n - mark, 6);
      expect_ev("R2 start", mark, EV_START, 0);
      expect_ev("R3 address", mark + 1, rw ? EV_ARD : EV_AWR,
                addr_raw ? int'(a) : int'(a >> 1));
      expect_ev("R4 address ack", mark + 2, aa ? EV_NACK : EV_ACK, 0);
      expect_ev("R5 data", mark + 3, rw ? EV_DRD : EV_DWR, int'(d));
      expect_ev("R4 data ack", mark + 4, da ? EV_NACK : EV_ACK, 0);
      expect_ev("R7 stop", mark + 5, EV_STOP, 0);
      expect_counts("R9", dmark);
    end
    addr_raw = 1'b0;

    // R8: idle activity without a start
    mark = ev_n;
    put(1'b0, 1'b1);
    put(1'b0, 1'b0);
    put(1'b1, 1'b0);
    put(1'b1, 1'b1);
    send_byte(8'hA5);
    put(1'b0, sda_d);
    put(1'b0, 1'b1);
    put(1'b1, 1'b1);
    settle();
    chk("R8 no events in idle", ev_n - mark, 0);

    // R8: conditions inside address byte and acknowledge slot are ignored
    mark = ev_n;
    dmark = done_n;
    bus_start();
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    put(1'b1, 1'b0);
    put(1'b1, 1'b1);
    send_bit(1'b0);
    send_bit(1'b0);
    send_bit(1'b0);
    send_bit(1'b0);
    send_bit(1'b0);
    put(1'b1, 1'b1);
    put(1'b1, 1'b0);
    send_bit(1'b0);
    send_byte(8'h12);
    send_bit(1'b0);
    bus_stop();
    settle();
    chk("R8 event count with glitches", ev_n - mark, 6);
    expect_ev("R8 start", mark, EV_START, 0);
    expect_ev("R8 address", mark + 1, EV_AWR, 8'h50);
    expect_ev("R8 ack", mark + 2, EV_ACK, 0);
    expect_ev("R8 data", mark + 3, EV_DWR, 8'h12);
    expect_ev("R8 stop", mark + 5, EV_STOP, 0);
    expect_counts("R9 glitch frame", dmark);

    // R6: repeated start switching direction
    mark = ev_n;
    dmark = done_n;
    bus_start();
    send_byte(8'hA2);
    send_bit(1'b0);
    send_byte(8'h11);
    send_bit(1'b0);
    bus_start();
    send_byte(8'hA3);
    send_bit(1'b0);
    send_byte(8'h22);
    send_bit(1'b1);
    bus_stop();
    settle();
    chk("R6 event count", ev_n - mark, 11);
    expect_ev("R6 first start", mark, EV_START, 0);
    expect_ev("R6 write data", mark + 3, EV_DWR, 8'h11);
    expect_ev("R6 repeated start", mark + 5, EV_RSTART, 0);
    expect_ev("R6 new address", mark + 6, EV_ARD, 8'h51);
    expect_ev("R6 read data", mark + 8, EV_DRD, 8'h22);
    expect_ev("R6 nack", mark + 9, EV_NACK, 0);
    expect_ev("R6 stop", mark + 10, EV_STOP, 0);
    expect_counts("R9 after repeated start", dmark);

    // R7: stop part-way through a data byte, then a fresh frame
    mark = ev_n;
    dmark = done_n;
    bus_start();
    send_byte(8'h20);
    send_bit(1'b0);
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    bus_stop();
    settle();
    chk("R7 event count mid-byte stop", ev_n - mark, 4);
    expect_ev("R7 address", mark + 1, EV_AWR, 8'h10);
    expect_ev("R7 mid-byte stop", mark + 3, EV_STOP, 0);
    expect_counts("R9 short frame", dmark);

    // R5 and R7: fresh start after stop, two read data bytes
    mark = ev_n;
    dmark = done_n;
    bus_start();
    send_byte(8'h21);
    send_bit(1'b0);
    send_byte(8'h99);
    send_bit(1'b0);
    send_byte(8'h66);
    send_bit(1'b1);
    bus_stop();
    settle();
    chk("R5 event count", ev_n - mark, 8);
    expect_ev("R7 start after stop", mark, EV_START, 0);
    expect_ev("R5 address", mark + 1, EV_ARD, 8'h10);
    expect_ev("R5 first read byte", mark + 3, EV_DRD, 8'h99);
    expect_ev("R5 second read byte", mark + 5, EV_DRD, 8'h66);
    expect_ev("R5 stop", mark + 7, EV_STOP, 0);
    expect_counts("R9 two-byte frame", dmark);

    chk("R11 single-cycle strobes", pulse_err, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule